// File: doc/BRIEF.md
# Square-Wave DDS Clock Controller

This block is a programmable frequency synthesizer for a video output clock. A phase accumulator advances by a programmed frequency word, and the most significant bit of the accumulator is the square-wave output. The accumulator runs at three times the control clock. It is built in the control-clock domain as three phase steps per cycle, and it delivers three ordered square-wave samples each cycle for an external serializer. A new frequency word is held back for a fixed settling delay before the accumulator uses it.

Around the synthesizer sits the digital half of a phase-locked loop that cleans the square wave. A control word written over a small register interface sets three things: a 2-bit source select, a reference divider S, and a feedback divider T. The divided square wave and the divided, synchronized oscillator input feed a digital phase detector that issues up and down pulses. The loop is switched on by the first control write that selects something other than the raw synthesizer output. A lock-timeout counter flags a sticky error if the external lock indication does not arrive in time. The analog oscillator and loop filter are outside the block; `vco_in` stands in for the oscillator.

Top module: `dds_clkgen`

## Requirements
- R1: During and directly after synchronous reset, `sq_samples`, `ref_pulse`, `fb_pulse`, `pd_up`, `pd_dn`, `pll_en`, `locked` and `lock_err` are 0, and `src_sel` is 2'b11.
- R2: A write with `wr_addr`=0 stores `wr_data` as a pending frequency word. The accumulator first steps with it on the 32nd clock edge after the write edge. A further frequency write while one is pending replaces it and restarts the delay.
- R3: On each cycle the accumulator (width ACC_W, modulo 2^ACC_W) advances by three times the active frequency word. Bit k of `sq_samples` is the MSB of the old accumulator plus (k+1) times the word, so bit 2 is the current square-wave level.
- R4: A write with `wr_addr`=1 loads `src_sel`=`wr_data[1:0]`, S=`wr_data[5:2]` and T=`wr_data[9:6]`. If the select is not 2'b11, `pll_en` becomes 1 on that edge. If the select is 2'b11, `pll_en` and `locked` become 0 on that edge.
- R5: While `pll_en` is 1, `ref_pulse` is high for one cycle on every (S+1)-th rising edge of `sq_samples[2]`. While `pll_en` is 0 the divider is cleared.
- R6: `vco_in` passes through a two-flop synchronizer. While `pll_en` is 1, `fb_pulse` is high for one cycle on every (T+1)-th synchronized rising edge.
- R7: One cycle after the divider pulses, `pd_up` is 1 when only `ref_pulse` was high and `pd_dn` is 1 when only `fb_pulse` was high. The two are never high together.
- R8: When a control write turns `pll_en` from 0 to 1, a timer starts. If `lock_in` stays low for LOCK_US*CYC_PER_US cycles after that edge, `lock_err` rises and stays 1 until reset.
- R9: `locked` equals `lock_in` sampled while the loop is enabled. Frequency-word writes do not change `pll_en` or `locked`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Control clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 1 | 0 selects the frequency word, 1 the control word |
| wr_data | input | ACC_W | Write data |
| vco_in | input | 1 | Oscillator clock stand-in, asynchronous |
| lock_in | input | 1 | External lock indication |
| sq_samples | output | OVS | Square-wave samples, one per phase step |
| src_sel | output | 2 | Registered output clock source select |
| ref_pulse | output | 1 | Divided reference pulse |
| fb_pulse | output | 1 | Divided feedback pulse |
| pd_up | output | 1 | Phase detector up pulse |
| pd_dn | output | 1 | Phase detector down pulse |
| pll_en | output | 1 | Loop enable |
| locked | output | 1 | Lock status |
| lock_err | output | 1 | Sticky lock-timeout error |

## Verification
The assertions check on every cycle that a pending word leaves the active word untouched until its delay ends, that divider pulses last one cycle, and that the enable and disable writes act on the next edge. They also check that `locked` never stands without `pll_en`, that the timeout error never falls, and that up and down never coincide. Several behaviours show only in the bench's scenarios, where a behavioural model is compared every clock: the exact cycle on which a delayed word starts to act, the phase pattern of the three samples, the divider ratios, and the timeout firing exactly at its limit.

// File: rtl/dds_pkg.sv
package dds_pkg;
  localparam logic [1:0] SEL_RAW = 2'b11;
  localparam logic ADDR_FREQ = 1'b0;
  localparam logic ADDR_CTRL = 1'b1;
endpackage

// File: rtl/dds_phase_acc.sv
module dds_phase_acc #(
  parameter int ACC_W     = 16,
  parameter int OVS       = 3,
  parameter int UPD_DELAY = 31
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             freq_wr,
  input  logic [ACC_W-1:0] freq_data,
  output logic [OVS-1:0]   samples
);
  localparam int CNT_W = $clog2(UPD_DELAY + 1);

  logic [ACC_W-1:0] acc, active, pend;
  logic             pend_v;
  logic [CNT_W-1:0] cnt;
  logic [ACC_W-1:0] part [OVS];
  logic [OVS-1:0]   msb_d;

  // settling delay for a new word (R2)
  always_ff @(posedge clk) begin
    if (rst) begin
      active <= '0;
      pend   <= '0;
      pend_v <= 1'b0;
      cnt    <= '0;
    end else if (freq_wr) begin
      pend   <= freq_data;
      pend_v <= 1'b1;
      cnt    <= CNT_W'(UPD_DELAY - 1);
    end else if (pend_v) begin
      if (cnt == '0) begin
        active <= pend;
        pend_v <= 1'b0;
      end else begin
        cnt <= cnt - 1'b1;
      end
    end
  end

  // one adder tap per phase step (R3)
  for (genvar k = 0; k < OVS; k++) begin : g_step
    assign part[k]  = acc + ACC_W'(k + 1) * active;
    assign msb_d[k] = part[k][ACC_W-1];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      acc     <= '0;
      samples <= '0;
    end else begin
      acc     <= part[OVS-1];
      samples <= msb_d;
    end
  end

  a_r2_hold_active: assert property (@(posedge clk) disable iff (rst)
    (pend_v && cnt != '0) |=> $stable(active));
  a_r2_load_pending: assert property (@(posedge clk) disable iff (rst)
    (pend_v && cnt == '0 && !freq_wr) |=> (active == $past(pend)));
endmodule

// File: rtl/dds_edge_div.sv
module dds_edge_div #(
  parameter int DIV_W = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en,
  input  logic             tick,
  input  logic [DIV_W-1:0] div,
  output logic             pulse
);
  logic [DIV_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst || !en) begin
      cnt   <= '0;
      pulse <= 1'b0;
    end else if (tick) begin
      if (cnt >= div) begin
        cnt   <= '0;
        pulse <= 1'b1;
      end else begin
        cnt   <= cnt + 1'b1;
        pulse <= 1'b0;
      end
    end else begin
      pulse <= 1'b0;
    end
  end

  // R5 / R6: pulses are single-cycle
  a_r5_single_pulse: assert property (@(posedge clk) disable iff (rst)
    pulse |=> !pulse);
  a_r6_quiet_when_off: assert property (@(posedge clk) disable iff (rst)
    !en |=> !pulse);
endmodule

// File: rtl/dds_pll_ctrl.sv
module dds_pll_ctrl
  import dds_pkg::*;
#(
  parameter int LOCK_LIMIT = 1350
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       ctl_wr,
  input  logic [1:0] ctl_sel,
  input  logic       lock_in,
  output logic       pll_en,
  output logic       locked,
  output logic       lock_err
);
  localparam int TIM_W = $clog2(LOCK_LIMIT + 1);

  logic             en_d, start;
  logic [TIM_W-1:0] timer;
  logic             timing;

  assign en_d  = ctl_wr ? (ctl_sel != SEL_RAW) : pll_en;
  assign start = ctl_wr && (ctl_sel != SEL_RAW) && !pll_en;

  always_ff @(posedge clk) begin
    if (rst) begin
      pll_en   <= 1'b0;
      locked   <= 1'b0;
      lock_err <= 1'b0;
      timer    <= '0;
      timing   <= 1'b0;
    end else begin
      pll_en <= en_d;
      locked <= en_d && lock_in;
      if (!en_d) begin
        timing <= 1'b0;
      end else if (start) begin
        timer  <= '0;
        timing <= 1'b1;
      end else if (timing) begin
        if (lock_in) begin
          timing <= 1'b0;
        end else if (timer == TIM_W'(LOCK_LIMIT - 1)) begin
          lock_err <= 1'b1;
          timing   <= 1'b0;
        end else begin
          timer <= timer + 1'b1;
        end
      end
    end
  end

  a_r4_enable: assert property (@(posedge clk) disable iff (rst)
    (ctl_wr && ctl_sel != SEL_RAW) |=> pll_en);
  a_r4_disable: assert property (@(posedge clk) disable iff (rst)
    (ctl_wr && ctl_sel == SEL_RAW) |=> (!pll_en && !locked));
  a_r9_lock_needs_en: assert property (@(posedge clk) disable iff (rst)
    locked |-> pll_en);
  a_r8_err_sticky: assert property (@(posedge clk) disable iff (rst)
    lock_err |=> lock_err);
endmodule

// File: rtl/dds_clkgen.sv
module dds_clkgen
  import dds_pkg::*;
#(
  parameter int ACC_W      = 16,
  parameter int DIV_W      = 4,
  parameter int OVS        = 3,
  parameter int UPD_DELAY  = 31,
  parameter int LOCK_US    = 50,
  parameter int CYC_PER_US = 27
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic             wr_addr,
  input  logic [ACC_W-1:0] wr_data,
  input  logic             vco_in,
  input  logic             lock_in,
  output logic [OVS-1:0]   sq_samples,
  output logic [1:0]       src_sel,
  output logic             ref_pulse,
  output logic             fb_pulse,
  output logic             pd_up,
  output logic             pd_dn,
  output logic             pll_en,
  output logic             locked,
  output logic             lock_err
);
  localparam int LOCK_LIMIT = LOCK_US * CYC_PER_US;
  localparam int S_LSB      = 2;
  localparam int T_LSB      = 2 + DIV_W;

  logic             freq_wr, ctl_wr;
  logic [DIV_W-1:0] s_div, t_div;
  logic             vco_s1, vco_s2, vco_prev, prev_sq;
  logic             ref_tick, fb_tick;

  assign freq_wr = wr_en && (wr_addr == ADDR_FREQ);
  assign ctl_wr  = wr_en && (wr_addr == ADDR_CTRL);

  always_ff @(posedge clk) begin
    if (rst) begin
      src_sel <= SEL_RAW;
      s_div   <= '0;
      t_div   <= '0;
    end else if (ctl_wr) begin
      src_sel <= wr_data[1:0];
      s_div   <= wr_data[S_LSB +: DIV_W];
      t_div   <= wr_data[T_LSB +: DIV_W];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      vco_s1   <= 1'b0;
      vco_s2   <= 1'b0;
      vco_prev <= 1'b0;
      prev_sq  <= 1'b0;
    end else begin
      vco_s1   <= vco_in;
      vco_s2   <= vco_s1;
      vco_prev <= vco_s2;
      prev_sq  <= sq_samples[OVS-1];
    end
  end

  assign ref_tick = sq_samples[OVS-1] && !prev_sq;
  assign fb_tick  = vco_s2 && !vco_prev;

  dds_phase_acc #(.ACC_W(ACC_W), .OVS(OVS), .UPD_DELAY(UPD_DELAY)) acc_i (
    .clk(clk), .rst(rst), .freq_wr(freq_wr), .freq_data(wr_data),
    .samples(sq_samples));

  dds_edge_div #(.DIV_W(DIV_W)) ref_div_i (
    .clk(clk), .rst(rst), .en(pll_en), .tick(ref_tick), .div(s_div),
    .pulse(ref_pulse));

  dds_edge_div #(.DIV_W(DIV_W)) fb_div_i (
    .clk(clk), .rst(rst), .en(pll_en), .tick(fb_tick), .div(t_div),
    .pulse(fb_pulse));

  dds_pll_ctrl #(.LOCK_LIMIT(LOCK_LIMIT)) ctrl_i (
    .clk(clk), .rst(rst), .ctl_wr(ctl_wr), .ctl_sel(wr_data[1:0]),
    .lock_in(lock_in), .pll_en(pll_en), .locked(locked),
    .lock_err(lock_err));

  // digital phase detector (R7)
  always_ff @(posedge clk) begin
    if (rst) begin
      pd_up <= 1'b0;
      pd_dn <= 1'b0;
    end else begin
      pd_up <= ref_pulse && !fb_pulse;
      pd_dn <= fb_pulse && !ref_pulse;
    end
  end

  a_r7_exclusive: assert property (@(posedge clk) disable iff (rst)
    !(pd_up && pd_dn));
  a_r7_up_cause: assert property (@(posedge clk) disable iff (rst)
    ref_pulse && !fb_pulse |=> pd_up);
  a_r9_freq_keeps_lock: assert property (@(posedge clk) disable iff (rst)
    (freq_wr && pll_en) |=> pll_en);
endmodule

// File: tb/dds_clkgen_tb.sv
module dds_clkgen_tb_top;
  localparam int ACC_W = 16;
  localparam int DIV_W = 4;
  localparam int LIMIT = 100;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic wr_en = 1'b0, wr_addr = 1'b0, vco_in = 1'b0, lock_in = 1'b0;
  logic [ACC_W-1:0] wr_data = '0;
  logic [2:0] sq_samples;
  logic [1:0] src_sel;
  logic ref_pulse, fb_pulse, pd_up, pd_dn, pll_en, locked, lock_err;

  int total = 0, bad = 0;
  bit done = 0, vco_run = 0;

  always #4 clk = ~clk;

  dds_clkgen #(.ACC_W(ACC_W), .DIV_W(DIV_W), .OVS(3), .UPD_DELAY(31),
               .LOCK_US(50), .CYC_PER_US(2)) dut_i (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .vco_in(vco_in), .lock_in(lock_in),
    .sq_samples(sq_samples), .src_sel(src_sel), .ref_pulse(ref_pulse),
    .fb_pulse(fb_pulse), .pd_up(pd_up), .pd_dn(pd_dn), .pll_en(pll_en),
    .locked(locked), .lock_err(lock_err));

  task automatic check(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  // behavioural reference model, one update per rising edge
  int m_acc, m_act, m_pend, m_pv, m_cnt, m_bits, m_psq;
  int m_rc, m_ref, m_fc, m_fb, m_v1, m_v2, m_vp, m_up, m_dn;
  int m_en, m_sel, m_s, m_t, m_lock, m_tim, m_timing, m_err;

  always @(posedge clk) begin
    if (rst) begin
      m_acc = 0; m_act = 0; m_pend = 0; m_pv = 0; m_cnt = 0; m_bits = 0;
      m_psq = 0; m_rc = 0; m_ref = 0; m_fc = 0; m_fb = 0; m_v1 = 0;
      m_v2 = 0; m_vp = 0; m_up = 0; m_dn = 0; m_en = 0; m_sel = 3;
      m_s = 0; m_t = 0; m_lock = 0; m_tim = 0; m_timing = 0; m_err = 0;
    end else begin
      int wf, wc, rt, ft, sq, nb, en_d, start, d;
      d  = int'(wr_data);
      wf = (wr_en && !wr_addr) ? 1 : 0;
      wc = (wr_en && wr_addr) ? 1 : 0;
      sq = (m_bits >> 2) & 1;
      // phase detector from previous pulses
      m_up = (m_ref && !m_fb) ? 1 : 0;
      m_dn = (m_fb && !m_ref) ? 1 : 0;
      // dividers
      rt = (sq && !m_psq) ? 1 : 0;
      ft = (m_v2 && !m_vp) ? 1 : 0;
      if (!m_en) begin m_rc = 0; m_ref = 0; end
      else if (rt) begin
        if (m_rc >= m_s) begin m_rc = 0; m_ref = 1; end
        else begin m_rc++; m_ref = 0; end
      end else m_ref = 0;
      if (!m_en) begin m_fc = 0; m_fb = 0; end
      else if (ft) begin
        if (m_fc >= m_t) begin m_fc = 0; m_fb = 1; end
        else begin m_fc++; m_fb = 0; end
      end else m_fb = 0;
      m_psq = sq;
      m_vp = m_v2; m_v2 = m_v1; m_v1 = vco_in ? 1 : 0;
      // accumulator with the word active before this edge
      nb = 0;
      for (int k = 0; k < 3; k++)
        nb |= (((m_acc + (k + 1) * m_act) & 16'hFFFF) >> 15) << k;
      m_bits = nb;
      m_acc = (m_acc + 3 * m_act) & 16'hFFFF;
      // delayed word update
      if (wf) begin m_pend = d; m_pv = 1; m_cnt = 30; end
      else if (m_pv) begin
        if (m_cnt == 0) begin m_act = m_pend; m_pv = 0; end
        else m_cnt--;
      end
      // loop control
      en_d  = wc ? (((d & 3) != 3) ? 1 : 0) : m_en;
      start = (wc && (d & 3) != 3 && !m_en) ? 1 : 0;
      if (!en_d) m_timing = 0;
      else if (start) begin m_tim = 0; m_timing = 1; end
      else if (m_timing) begin
        if (lock_in) m_timing = 0;
        else if (m_tim == LIMIT - 1) begin m_err = 1; m_timing = 0; end
        else m_tim++;
      end
      m_lock = (en_d && lock_in) ? 1 : 0;
      m_en = en_d;
      if (wc) begin m_sel = d & 3; m_s = (d >> 2) & 15; m_t = (d >> 6) & 15; end
    end
  end

  // per-cycle comparison away from the active edge
  always @(negedge clk) begin
    if (!done) begin
      check("R3 sq_samples", int'(sq_samples), m_bits);
      check("R4 src_sel", int'(src_sel), m_sel);
      check("R4 pll_en", int'(pll_en), m_en);
      check("R9 locked", int'(locked), m_lock);
      check("R5 ref_pulse", int'(ref_pulse), m_ref);
      check("R6 fb_pulse", int'(fb_pulse), m_fb);
      check("R7 pd_up", int'(pd_up), m_up);
      check("R7 pd_dn", int'(pd_dn), m_dn);
      check("R8 lock_err", int'(lock_err), m_err);
    end
  end

  // oscillator stand-in: period of six cycles
  initial begin
    forever begin
      repeat (3) @(negedge clk);
      if (vco_run) vco_in = ~vco_in;
    end
  end

  task automatic wr(input logic a, input int d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = ACC_W'(d);
    @(negedge clk);
    wr_en = 1'b0; wr_data = '0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    check("R1 reset sq", int'(sq_samples), 0);
    check("R1 reset sel", int'(src_sel), 3);
    check("R1 reset en", int'(pll_en | locked | lock_err), 0);
    rst = 1'b0;
    @(negedge clk);
    check("R1 after reset pulses", int'(ref_pulse | fb_pulse | pd_up | pd_dn), 0);

    // R2: delayed word, R3: sample pattern 0x3000 -> 3'b100
    wr(1'b0, 16'h3000);
    repeat (31) @(negedge clk);
    check("R2 word not yet used", int'(sq_samples), 0);
    @(negedge clk);
    check("R3 first step pattern", int'(sq_samples), 4);
    repeat (10) @(negedge clk);

    // R4: enable with S=1, T=2, select 00
    vco_run = 1;
    wr(1'b1, (1 << 2) | (2 << 6));
    check("R4 enable", int'(pll_en), 1);
    repeat (60) @(negedge clk);
    check("R8 no error yet", int'(lock_err), 0);
    repeat (45) @(negedge clk);
    check("R8 timeout error", int'(lock_err), 1);

    // R4: select 11 disables
    wr(1'b1, 3);
    check("R4 disable", int'(pll_en), 0);
    check("R4 disable lock", int'(locked), 0);
    repeat (10) @(negedge clk);
    check("R5 divider idle", int'(ref_pulse | fb_pulse), 0);

    // R9: re-enable with lock present, S=0, T=1
    lock_in = 1'b1;
    wr(1'b1, 1 | (0 << 2) | (1 << 6));
    check("R9 locked", int'(locked), 1);
    check("R8 error sticky", int'(lock_err), 1);
    wr(1'b0, 16'h0800);
    repeat (40) @(negedge clk);
    check("R9 freq write keeps lock", int'(locked & pll_en), 1);

    // R2: restart of a pending word
    wr(1'b0, 16'h5000);
    repeat (10) @(negedge clk);
    wr(1'b0, 16'h1100);
    repeat (60) @(negedge clk);
    lock_in = 1'b0;
    repeat (2) @(negedge clk);
    check("R9 lock follows input", int'(locked), 0);
    repeat (20) @(negedge clk);
    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      total++; bad++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule